// File: doc/BRIEF.md
# Masked Fixed-Priority Interrupt Controller

This block gathers interrupt events from four request lines into a pending register, filters them through a software-owned mask, and picks one winner with a fixed-priority encoder. Line 0 has the highest priority and line 3 the lowest. The winner's number becomes two bits of an 8-bit vector address. The processor receives a single interrupt line, which is raised only when the global enable bit is set and at least one unmasked source is pending.

When the processor acknowledges the interrupt, the block captures the vector and presents it for as long as the acknowledge is held. In the same cycle it drops the global enable, so a second interrupt cannot nest until software turns the enable on again.

Software reaches the pending, mask and control registers through a small write/read port. It clears a serviced source by writing a 1 to that source's pending bit. Stack and program-counter handling belong to the processor and are not part of this block.

Top module: `pic_unit`

## Requirements
- R1: After a synchronous active-low reset, the pending bits, the mask bits and the enable are all 0. The interrupt output and the vector-valid output are low, and every register reads 0.
- R2: A 0-to-1 change on request line i, sampled at a clock edge, sets pending bit i at that edge. A line held high does not set its bit again after the bit is cleared; only the next rising change does.
- R3: A write of address 0 clears every pending bit whose write-data bit is 1 and leaves the other bits unchanged. If a bit is cleared and sees a new rising request in the same cycle, the rising request wins and the bit stays set.
- R4: Register map. Address 0 reads the pending bits in [3:0]. Address 1 is the mask in [3:0] and is read/write. Address 2 holds the enable in bit 0 (read/write) and a read-only status flag in bit 1 that is 1 when any unmasked source is pending. Address 3 reads 0, and all unused bits read 0.
- R5: A pending bit whose mask bit is 0 has no effect on the interrupt output, the status flag or the vector choice.
- R6: The interrupt output is high exactly when the enable is 1 and the status flag is 1.
- R7: The winner is the lowest-numbered source that is both pending and unmasked. The vector is base 0x40 with the winner's number in bits [2:1], giving 0x40, 0x42, 0x44 or 0x46. If nothing is pending, the number field is 0.
- R8: At the clock edge where the acknowledge input is first seen high, the vector is captured and the enable is cleared. A software write to the enable in that same cycle loses. From the next cycle, vector-valid is high and the vector output shows the captured value. Both return to 0 at the first edge where the acknowledge is seen low. While vector-valid is low, the vector output is 0.
- R9: While vector-valid is high, the vector output does not change, even if requests, mask writes or clears arrive.
- R10: An acknowledge leaves the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src_i | input | 4 | Request lines; a rising change records an event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt to the processor |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| vec_o | output | 8 | Captured vector address, 0 when not valid |
| vec_valid_o | output | 1 | High while a captured vector is presented |

## Verification
Every register updates at the clock edge that samples its cause: a request edge, a write or an acknowledge. The interrupt output and the read data are combinational from those registers and the current address, so each is due one edge after its stimulus. The vector output appears one edge after the acknowledge and disappears one edge after the acknowledge drops. The bench drives inputs at the falling edge, updates its reference model at the following rising edge, and compares every output at the next falling edge, just before it drives new inputs.

// File: rtl/pic_pkg.sv
// Shared definitions for the masked priority interrupt controller.
// Assumes a two-bit register address space.
package pic_pkg;
    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_ST_BIT = 1;
endpackage

// File: rtl/pic_req_latch.sv
// Records rising edges of the request lines into pending bits; software
// clears bits with a clear vector. Assumes requests are already synchronous.
module pic_req_latch #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] rise;

    // detect a 0-to-1 change since the previous edge
    assign rise = src_i & ~src_q;

    // remember last request level
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    // pending bits: a new edge wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | rise;
    end

    assign pend_o = pend_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (src_i[i] && !src_q[i]) |=> pend_q[i]);
        assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !(src_i[i] && !src_q[i])) |=> !pend_q[i]);
    end
endmodule

// File: rtl/pic_prio_enc.sv
// Fixed-priority encoder: the lowest index among the requests wins.
// Purely combinational. Assumes NUM_SRC fits in IDX_W bits.
module pic_prio_enc #(
    parameter int NUM_SRC = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] grant_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);
    logic [NUM_SRC:0] blocked;

    assign blocked[0] = 1'b0;

    // priority chain: a request blocks every higher index
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
        assign grant_o[i]   = req_i[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req_i[i];
    end

    // binary index of the single granted line
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign any_o = blocked[NUM_SRC];
endmodule

// File: rtl/pic_ack_ctrl.sv
// Holds the global enable and captures the vector on an acknowledge.
// Assumes ack_i is synchronous; the acknowledge clear beats a software write.
module pic_ack_ctrl #(
    parameter int          VEC_W    = 8,
    parameter int          IDX_W    = 2,
    parameter logic [7:0]  VEC_BASE = 8'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_i,
    input  logic             en_wr_i,
    input  logic             en_wdata_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             en_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid_o
);
    logic             ack_q;
    logic             ack_rise;
    logic             en_q;
    logic             valid_q;
    logic [VEC_W-1:0] vec_q;
    logic [VEC_W-1:0] vec_new;

    assign ack_rise = ack_i & ~ack_q;

    // build the vector: base with the index in bits [IDX_W:1]
    always_comb begin
        vec_new = VEC_W'(VEC_BASE);
        vec_new[IDX_W:1] = idx_i;
    end

    // track acknowledge level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_i;
    end

    // global enable: written by software, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (ack_rise) en_q <= 1'b0;
        else if (en_wr_i)  en_q <= en_wdata_i;
    end

    // vector capture and valid window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            vec_q   <= '0;
        end else if (ack_rise) begin
            valid_q <= 1'b1;
            vec_q   <= vec_new;
        end else if (!ack_i) begin
            valid_q <= 1'b0;
        end
    end

    assign en_o        = en_q;
    assign vec_valid_o = valid_q;
    assign vec_o       = valid_q ? vec_q : '0;

    assert_ack_drops_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !ack_q) |=> (!en_q && valid_q));
    assert_vec_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && $past(valid_q)) |-> $stable(vec_o));
endmodule

// File: rtl/pic_unit.sv
// Top of the masked priority interrupt controller: pending latch, mask
// register, fixed-priority encoder and acknowledge control.
// Assumes all inputs are synchronous to clk.
module pic_unit #(
    parameter int         NUM_SRC  = 4,
    parameter int         DATA_W   = 8,
    parameter int         VEC_W    = 8,
    parameter logic [7:0] VEC_BASE = 8'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o,
    input  logic               ack_i,
    output logic [VEC_W-1:0]   vec_o,
    output logic               vec_valid_o
);
    import pic_pkg::*;

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] masked;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   win_idx;
    logic               status;
    logic               en;

    assign sel    = reg_sel_e'(reg_addr_i);
    assign clr    = (reg_wr_i && sel == SEL_PEND) ? reg_wdata_i[NUM_SRC-1:0] : '0;
    assign masked = pend & mask_q;

    pic_req_latch #(.NUM_SRC(NUM_SRC)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (irq_src_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    // mask register, written by software
    always_ff @(posedge clk) begin
        if (!rst_n)                         mask_q <= '0;
        else if (reg_wr_i && sel == SEL_MASK) mask_q <= reg_wdata_i[NUM_SRC-1:0];
    end

    pic_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
        .req_i   (masked),
        .grant_o (grant),
        .idx_o   (win_idx),
        .any_o   (status)
    );

    pic_ack_ctrl #(.VEC_W(VEC_W), .IDX_W(IDX_W), .VEC_BASE(VEC_BASE)) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .en_wr_i     (reg_wr_i && sel == SEL_CTRL),
        .en_wdata_i  (reg_wdata_i[CTRL_EN_BIT]),
        .idx_i       (win_idx),
        .en_o        (en),
        .vec_o       (vec_o),
        .vec_valid_o (vec_valid_o)
    );

    assign irq_o = en & status;

    // register read multiplexer
    always_comb begin
        reg_rdata_o = '0;
        case (sel)
            SEL_PEND: reg_rdata_o[NUM_SRC-1:0] = pend;
            SEL_MASK: reg_rdata_o[NUM_SRC-1:0] = mask_q;
            SEL_CTRL: begin
                reg_rdata_o[CTRL_EN_BIT] = en;
                reg_rdata_o[CTRL_ST_BIT] = status;
            end
            default:  reg_rdata_o = '0;
        endcase
    end

    assert_winner_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked) |-> (masked[win_idx] &&
            ((masked & ((NUM_SRC'(1) << win_idx) - NUM_SRC'(1))) == '0)));
    assert_grant_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (masked == '0) |-> !irq_o);
endmodule

// File: tb/pic_unit_tb.sv
// Self-checking bench: reference model updated at each rising edge,
// outputs compared at the falling edge before new inputs are driven.
module pic_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irq_src_i = '0;
    logic       reg_wr_i = 1'b0;
    logic [1:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_o;
    logic       ack_i = 1'b0;
    logic [7:0] vec_o;
    logic       vec_valid_o;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    logic [3:0] m_pend, m_mask, m_src_prev;
    logic       m_ien, m_vvalid, m_ack_prev;
    logic [7:0] m_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_unit dut_i (
        .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .irq_o(irq_o), .ack_i(ack_i), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
    );

    // R7: vector from masked pending bits, lowest index wins
    function automatic logic [7:0] exp_vec(input logic [3:0] m);
        logic [1:0] idx = 2'd0;
        for (int i = 3; i >= 0; i--) if (m[i]) idx = 2'(i);
        return 8'h40 | {5'd0, idx, 1'b0};
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return {4'd0, m_pend};
            2'd1: return {4'd0, m_mask};
            2'd2: return {6'd0, |(m_pend & m_mask), m_ien};
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("irq_o (R6)", {7'd0, irq_o}, {7'd0, m_ien & |(m_pend & m_mask)});
        chk("vec_valid_o (R8)", {7'd0, vec_valid_o}, {7'd0, m_vvalid});
        chk("vec_o (R8 R9)", vec_o, m_vvalid ? m_vec : 8'd0);
        chk("reg_rdata_o (R4)", reg_rdata_o, exp_rdata(reg_addr_i));
    endtask

    task automatic model_reset();
        m_pend = '0; m_mask = '0; m_src_prev = '0;
        m_ien = 1'b0; m_vvalid = 1'b0; m_ack_prev = 1'b0; m_vec = '0;
    endtask

    // apply the inputs sampled at this rising edge to the model
    task automatic model_update();
        logic [3:0] rise = irq_src_i & ~m_src_prev;
        logic       arise = ack_i & ~m_ack_prev;
        if (arise) m_vec = exp_vec(m_pend & m_mask);
        m_vvalid = ack_i ? (arise ? 1'b1 : m_vvalid) : 1'b0;
        if (reg_wr_i && reg_addr_i == 2'd0) m_pend = m_pend & ~reg_wdata_i[3:0];
        m_pend = m_pend | rise;
        if (reg_wr_i && reg_addr_i == 2'd1) m_mask = reg_wdata_i[3:0];
        if (arise) m_ien = 1'b0;
        else if (reg_wr_i && reg_addr_i == 2'd2) m_ien = reg_wdata_i[0];
        m_src_prev = irq_src_i;
        m_ack_prev = ack_i;
    endtask

    task automatic step(input logic [3:0] s, input logic w, input logic [1:0] a,
                        input logic [7:0] d, input logic k);
        @(negedge clk);
        check_all();
        irq_src_i = s; reg_wr_i = w; reg_addr_i = a; reg_wdata_i = d; ack_i = k;
        @(posedge clk);
        model_update();
    endtask

    initial begin
        void'($urandom(32'd20240917));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state through every register address
        cur_tag = "R1";
        for (int a = 0; a < 4; a++) step(4'h0, 1'b0, 2'(a), 8'h00, 1'b0);

        // R4: unused bits read zero, status bit read-only
        cur_tag = "R4";
        step(4'h0, 1'b1, 2'd1, 8'hFF, 1'b0);
        step(4'h0, 1'b1, 2'd2, 8'hFF, 1'b0);
        step(4'h0, 1'b0, 2'd2, 8'h00, 1'b0);
        step(4'h0, 1'b0, 2'd3, 8'h00, 1'b0);

        // R2: edge sets, held level does not retrigger after clear
        cur_tag = "R2";
        step(4'h1, 1'b0, 2'd0, 8'h00, 1'b0);
        step(4'h1, 1'b1, 2'd0, 8'h01, 1'b0);
        step(4'h1, 1'b0, 2'd0, 8'h00, 1'b0);
        step(4'h1, 1'b0, 2'd0, 8'h00, 1'b0);

        // R3: new edge in the clear cycle wins; other bits untouched
        cur_tag = "R3";
        step(4'h0, 1'b0, 2'd0, 8'h00, 1'b0);
        step(4'hA, 1'b0, 2'd0, 8'h00, 1'b0);
        step(4'hB, 1'b1, 2'd0, 8'h03, 1'b0);
        step(4'hB, 1'b1, 2'd0, 8'h08, 1'b0);
        step(4'hB, 1'b0, 2'd0, 8'h00, 1'b0);

        // R5: masked pending bits give no irq and no status
        cur_tag = "R5";
        step(4'h0, 1'b1, 2'd0, 8'h0F, 1'b0);
        step(4'hF, 1'b1, 2'd1, 8'h00, 1'b0);
        step(4'hF, 1'b1, 2'd2, 8'h01, 1'b0);
        step(4'hF, 1'b0, 2'd2, 8'h00, 1'b0);

        // R6 R7: unmask one source at a time, lowest wins; ack gives vector
        cur_tag = "R7";
        for (int m = 8; m >= 1; m = m >> 1) begin
            step(4'hF, 1'b1, 2'd1, 8'(m), 1'b0);
            step(4'hF, 1'b1, 2'd2, 8'h01, 1'b0);
            step(4'hF, 1'b0, 2'd2, 8'h00, 1'b1);
            step(4'hF, 1'b0, 2'd0, 8'h00, 1'b1);
            step(4'hF, 1'b0, 2'd0, 8'h00, 1'b0);
        end
        step(4'hF, 1'b1, 2'd1, 8'h0C, 1'b0);
        step(4'hF, 1'b0, 2'd2, 8'h00, 1'b1);

        // R8 R9 R10: vector held while ack high despite new activity
        cur_tag = "R9";
        step(4'h0, 1'b1, 2'd1, 8'h0F, 1'b1);
        step(4'h0, 1'b1, 2'd0, 8'h0C, 1'b1);
        step(4'h1, 1'b0, 2'd0, 8'h00, 1'b1);
        step(4'h1, 1'b0, 2'd0, 8'h00, 1'b0);

        // R8: enable write loses to an acknowledge edge in the same cycle
        cur_tag = "R8";
        step(4'h1, 1'b1, 2'd2, 8'h01, 1'b0);
        step(4'h1, 1'b1, 2'd2, 8'h01, 1'b1);
        step(4'h1, 1'b0, 2'd2, 8'h00, 1'b1);
        step(4'h1, 1'b0, 2'd0, 8'h00, 1'b0);

        // R7: nothing pending at acknowledge gives index 0
        step(4'h0, 1'b1, 2'd0, 8'h0F, 1'b0);
        step(4'h0, 1'b0, 2'd0, 8'h00, 1'b1);
        step(4'h0, 1'b0, 2'd0, 8'h00, 1'b0);

        // constrained random traffic
        cur_tag = "R2 R3 R4 R5 R6 R7 R8 R9 R10";
        begin
            logic [3:0] s = 4'h0;
            logic       k = 1'b0;
            for (int c = 0; c < RAND_CYCLES; c++) begin
                logic       w;
                logic [1:0] a;
                logic [7:0] d;
                if ($urandom % 3 == 0) s = 4'($urandom);
                if ($urandom % 5 == 0) k = ~k;
                w = ($urandom % 3 == 0);
                a = 2'($urandom);
                d = 8'($urandom);
                if (a == 2'd2 && ($urandom % 4 != 0)) d[0] = 1'b1;
                step(s, w, a, d, k);
            end
        end
        @(negedge clk);
        check_all();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule